// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes each instruction in one clock cycle. In the same cycle it fetches the instruction at the program counter, reads two source registers, runs the ALU, accesses data memory and writes the result back. It has one port for instruction fetch and a separate port for data memory, so a load or store does not compete with fetch. Both memories sit outside the core. Reads from them are combinational, and the data memory samples its write on the rising edge.

The instruction set is small: five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), a word load, a word store and branch-if-equal. Instructions are 32 bits long and use three fixed formats. The opcode is bits 31:26, the first source register (rs) is bits 25:21 and the second register (rt) is bits 20:16. Register-to-register instructions also use a destination field in bits 15:11, a shift field in bits 10:6 and a function code in bits 5:0. Loads, stores and branches instead use bits 15:0 as a signed 16-bit immediate. A synchronous, active-high reset clears the program counter and the register file.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and all registers become 0. The cycle after reset, `imem_addr` is 0.
- R2: Opcode 0x00 with shift field 0 and function code 0x20 writes R[rd] with R[rs] + R[rt] (modulo 2^32) at the next rising edge.
- R3: Opcode 0x00 with shift field 0 and function code 0x22, 0x24 or 0x25 writes R[rd] with R[rs] − R[rt], R[rs] & R[rt] or R[rs] | R[rt] respectively.
- R4: Opcode 0x00 with shift field 0 and function code 0x2A writes R[rd] with 1 when R[rs] < R[rt] as signed numbers, and with 0 otherwise.
- R5: Register 0 always reads as zero. A write aimed at it leaves it zero.
- R6: Opcode 0x23 (load) drives `dmem_addr` = R[rs] + sign-extended imm16 and writes R[rt] with `dmem_rdata` from the same cycle.
- R7: Opcode 0x2B (store) raises `dmem_we` in its fetch cycle, with `dmem_addr` = R[rs] + sign-extended imm16 and `dmem_wdata` = R[rt]. No other instruction raises `dmem_we`.
- R8: Opcode 0x04 (branch-if-equal) with R[rs] = R[rt] sets the next PC to PC + 4 + sign-extended imm16 × 4. This includes negative offsets.
- R9: A branch-if-equal with unequal registers, and every other instruction, sets the next PC to PC + 4.
- R10: Any other opcode, a function code outside the five listed, or a nonzero shift field makes the instruction a no-op: no register write, no memory write, and the next PC is PC + 4.
- R11: The two low bits of `imem_addr` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data, the value of R[rt] |
| dmem_we | output | 1 | Data memory write enable, sampled at the rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |

## Verification
The assertions assume that both memories answer combinationally within the cycle. They also assume that `imem_rdata` and `dmem_rdata` are always defined values, so a decode never sees X. Both memory models in the stimulus are fully initialised arrays indexed by the word address, so every fetch and load returns a known word, even for a wild address computed from random register contents. The random program keeps register numbers within a small window, so sources often alias destinations. Its branch offsets are short and include negative ones, so taken branches loop back and exercise the backward path without leaving the loaded program region.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN   = 32;
  localparam int IWIDTH = 32;
  localparam int RAW    = 5;
  localparam int IMMW   = 16;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    use_imm;
    logic    wb_mem;
    logic    mem_we;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] imm);
    return {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] br_pc(input logic [XLEN-1:0] pc,
                                           input logic [IMMW-1:0] imm);
    return pc + XLEN'(4) + (sext_imm(imm) << 2);
  endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [IWIDTH-1:0] instr,
  output ctrl_t             ctrl,
  output logic              illegal
);

  logic [5:0] opcode;
  logic [4:0] shamt;
  logic [5:0] funct;

  assign opcode = instr[31:26];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];

  always_comb begin
    ctrl    = '0;
    illegal = 1'b1;
    case (opcode)
      OPC_REG: begin
        if (shamt == 5'd0) begin
          ctrl.reg_we  = 1'b1;
          ctrl.dst_rd  = 1'b1;
          illegal      = 1'b0;
          case (funct)
            FN_ADD:  ctrl.alu_op = ALU_ADD;
            FN_SUB:  ctrl.alu_op = ALU_SUB;
            FN_AND:  ctrl.alu_op = ALU_AND;
            FN_OR:   ctrl.alu_op = ALU_OR;
            FN_SLT:  ctrl.alu_op = ALU_SLT;
            default: begin
              ctrl.reg_we = 1'b0;
              ctrl.dst_rd = 1'b0;
              illegal     = 1'b1;
            end
          endcase
        end
      end
      OPC_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.alu_op  = ALU_ADD;
        illegal      = 1'b0;
      end
      OPC_STORE: begin
        ctrl.mem_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_ADD;
        illegal      = 1'b0;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
        illegal     = 1'b0;
      end
      default: begin
        ctrl    = '0;
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG  = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    ra1,
  input  logic [AW-1:0]    ra2,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd
);

  logic [WIDTH-1:0] regs [NREG];
  logic             wr_fire;

  assign wr_fire = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  p_write_visible_r2: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (ra1 != $past(wa)) || (rd1 == $past(wd)));

  p_zero_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ra2 == '0) |-> (rd2 == '0));

  p_zero_write_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> (ra1 != '0) || (rd1 == '0));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            eq
);

  assign y  = alu_eval(op, a, b);
  assign eq = (alu_eval(ALU_SUB, a, b) == '0);

endmodule

// File: rtl/sc_pc.sv
module sc_pc
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [IMMW-1:0] offset,
  output logic [XLEN-1:0] pc
);

  logic [XLEN-1:0] pc_next;

  assign pc_next = take ? br_pc(pc, offset) : seq_pc(pc);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (pc == '0));

  p_pc_aligned_r11: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  p_seq_step_r9: assert property (@(posedge clk) disable iff (rst)
    !take |=> (pc == $past(pc) + XLEN'(4)));

  p_branch_step_r8: assert property (@(posedge clk) disable iff (rst)
    take |=> (pc - $past(pc) == XLEN'(4) + {{(XLEN-IMMW-2){$past(offset[IMMW-1])}}, $past(offset), 2'b00}));

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);

  localparam int AW = $clog2(NREG);

  logic [IWIDTH-1:0] instr;
  logic [AW-1:0]     rs_a, rt_a, rd_a, wa;
  logic [IMMW-1:0]   imm;
  logic [XLEN-1:0]   imm_x;
  logic [XLEN-1:0]   rs_val, rt_val;
  logic [XLEN-1:0]   alu_b, alu_y, rf_wd, pc;
  logic              alu_eq, take, rf_we, illegal;
  ctrl_t             ctrl;

  assign instr = imem_rdata;
  assign rs_a  = instr[25:21];
  assign rt_a  = instr[20:16];
  assign rd_a  = instr[15:11];
  assign imm   = instr[15:0];
  assign imm_x = sext_imm(imm);

  sc_decode u_dec (
    .instr   (instr),
    .ctrl    (ctrl),
    .illegal (illegal)
  );

  assign wa    = ctrl.dst_rd ? rd_a : rt_a;
  assign rf_we = ctrl.reg_we;

  sc_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (rs_a),
    .ra2 (rt_a),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .we  (rf_we),
    .wa  (wa),
    .wd  (rf_wd)
  );

  assign alu_b = ctrl.use_imm ? imm_x : rt_val;

  sc_alu u_alu (
    .op (ctrl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y),
    .eq (alu_eq)
  );

  assign take  = ctrl.branch && alu_eq;
  assign rf_wd = ctrl.wb_mem ? dmem_rdata : alu_y;

  sc_pc u_pc (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .offset (imm),
    .pc     (pc)
  );

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we;

  p_store_no_regwrite_r7: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);

  p_slt_boolean_r4: assert property (@(posedge clk) disable iff (rst)
    (rf_we && ctrl.alu_op == ALU_SLT && !ctrl.wb_mem) |-> (rf_wd[XLEN-1:1] == '0));

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rf_we && !dmem_we && !take));

  p_ctrl_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.branch}));

  p_taken_equal_r8: assert property (@(posedge clk) disable iff (rst)
    take |-> (rs_val == rt_val));

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [256];
  string       pc_tag;

  always #2 clk = ~clk;

  sc_core uut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    logic [31:0] r;
    r = {16'h0000, v};
    if (v[15]) r = r | 32'hFFFF_0000;
    return r;
  endfunction

  function automatic logic [31:0] ref_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a + ~b + 32'd1;
      6'h24:   return a & b;
      6'h25:   return a | b;
      default: begin
        if (a[31] != b[31]) return {31'd0, a[31]};
        return {31'd0, a < b};
      end
    endcase
  endfunction

  function automatic bit legal_fn(input logic [5:0] fn);
    return fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Compare ports against the model for the current cycle, then advance the model.
  task automatic step();
    logic [31:0] ins, a, b, ea;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    bit          is_r, is_ld, is_st, is_bq;
    ins = imem[m_pc[9:2]];
    op  = ins[31:26];
    fn  = ins[5:0];
    rs  = int'(ins[25:21]);
    rt  = int'(ins[20:16]);
    rd  = int'(ins[15:11]);
    a   = m_reg[rs];
    b   = m_reg[rt];
    ea  = a + sx(ins[15:0]);
    is_r  = (op == 6'h00) && (ins[10:6] == 5'd0) && legal_fn(fn);
    is_ld = (op == 6'h23);
    is_st = (op == 6'h2B);
    is_bq = (op == 6'h04);
    chk({pc_tag, " pc"}, imem_addr, m_pc);
    chk("R11 pc align", {30'd0, imem_addr[1:0]}, 32'd0);
    if (is_st) begin
      chk("R7 store we", {31'd0, dmem_we}, 32'd1);
      chk("R7 store addr", dmem_addr, ea);
      chk("R7 store data", dmem_wdata, b);
    end else if (is_ld) begin
      chk("R6 load we", {31'd0, dmem_we}, 32'd0);
      chk("R6 load addr", dmem_addr, ea);
    end else if (!is_r && !is_bq) begin
      chk("R10 no-op we", {31'd0, dmem_we}, 32'd0);
    end else begin
      chk("R7 we low", {31'd0, dmem_we}, 32'd0);
    end
    pc_tag = "R9";
    if (is_r && rd != 0) m_reg[rd] = ref_op(fn, a, b);
    if (is_ld && rt != 0) m_reg[rt] = m_mem[ea[9:2]];
    if (is_st) m_mem[ea[9:2]] = b;
    if (is_bq && a == b) begin
      m_pc   = m_pc + 32'd4 + {sx(ins[15:0]), 2'b00};
      pc_tag = "R8";
    end else begin
      m_pc = m_pc + 32'd4;
      if (!(is_r || is_ld || is_st || is_bq)) pc_tag = "R10";
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = 32'd0;
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    for (int i = 0; i < 256; i++) m_mem[i] = dmem[i];
    pc_tag = "R1";
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 256; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end

    // Directed program
    dmem[0]  = 32'h0000_00F7;
    dmem[1]  = 32'hFFFF_FFF0;
    dmem[2]  = 32'd64;
    dmem[14] = 32'h0000_7777;
    dmem[15] = 32'h0000_DEAD;
    dmem[16] = 32'h0000_5555;
    imem[0]  = enc_i(6'h23, 1, 0, 0);
    imem[1]  = enc_i(6'h23, 2, 0, 4);
    imem[2]  = enc_i(6'h23, 11, 0, 8);
    imem[3]  = enc_r(6'h20, 3, 1, 2);
    imem[4]  = enc_r(6'h22, 4, 1, 2);
    imem[5]  = enc_r(6'h24, 5, 1, 2);
    imem[6]  = enc_r(6'h25, 6, 1, 2);
    imem[7]  = enc_r(6'h2A, 7, 2, 1);
    imem[8]  = enc_r(6'h2A, 8, 1, 2);
    imem[9]  = enc_r(6'h20, 0, 1, 1);
    imem[10] = enc_i(6'h2B, 3, 0, 32);
    imem[11] = enc_i(6'h2B, 4, 0, 36);
    imem[12] = enc_i(6'h2B, 5, 0, 40);
    imem[13] = enc_i(6'h2B, 6, 0, 44);
    imem[14] = enc_i(6'h2B, 7, 0, 48);
    imem[15] = enc_i(6'h2B, 8, 0, 52);
    imem[16] = enc_i(6'h2B, 0, 0, 56);
    imem[17] = enc_i(6'h04, 2, 1, 5);
    imem[18] = enc_i(6'h04, 1, 1, 2);
    imem[19] = enc_i(6'h2B, 1, 0, 60);
    imem[20] = enc_i(6'h2B, 1, 0, 60);
    imem[21] = enc_i(6'h3F, 9, 1, 0);
    imem[22] = {6'h00, 5'd1, 5'd1, 5'd9, 5'd0, 6'h01};
    imem[23] = enc_i(6'h2B, 9, 0, 64);
    imem[24] = enc_i(6'h23, 10, 11, -4);
    imem[25] = enc_i(6'h2B, 10, 0, 68);
    imem[26] = enc_i(6'h04, 0, 0, -1);

    do_reset();
    chk("R1 reset pc", imem_addr, 32'd0);
    run(40);
    chk("R2 add", dmem[8], 32'h0000_00E7);
    chk("R3 sub", dmem[9], 32'h0000_0107);
    chk("R3 and", dmem[10], 32'h0000_00F0);
    chk("R3 or", dmem[11], 32'hFFFF_FFF7);
    chk("R4 slt true", dmem[12], 32'd1);
    chk("R4 slt false", dmem[13], 32'd0);
    chk("R5 r0 zero", dmem[14], 32'd0);
    chk("R8 skipped store", dmem[15], 32'h0000_DEAD);
    chk("R10 no write r9", dmem[16], 32'd0);
    chk("R6 load neg offset", dmem[17], 32'h0000_DEAD);
    chk("R8 self loop", imem_addr, 32'd104);

    // Random program
    for (int i = 0; i < 256; i++) begin
      int k;
      logic [5:0] fns [5];
      fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
      dmem[i] = $urandom;
      k = int'($urandom % 10);
      case (k)
        0, 1, 2, 3: imem[i] = enc_r(fns[$urandom % 5], int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
        4:          imem[i] = enc_i(6'h23, int'($urandom % 8), int'($urandom % 8), int'($urandom % 32) * 4 - 16);
        5:          imem[i] = enc_i(6'h2B, int'($urandom % 8), int'($urandom % 8), int'($urandom % 32) * 4 - 16);
        6:          imem[i] = enc_i(6'h04, int'($urandom % 4), int'($urandom % 4), int'($urandom % 8) - 3);
        7:          imem[i] = {6'h30 | 6'($urandom % 8), 26'($urandom)};
        8:          imem[i] = {6'h00, 15'($urandom), 5'd1 + 5'($urandom % 4), fns[$urandom % 5]};
        default:    imem[i] = {6'h00, 20'($urandom), 6'h10 + 6'($urandom % 8)};
      endcase
    end
    do_reset();
    chk("R1 reset pc again", imem_addr, 32'd0);
    run(3000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule